// File: doc/BRIEF.md
# Power Threshold Throttle Monitor

This block watches a measured power figure, given in whole watts, and decides how hard the attached workload must be slowed down. Software programs two 7-bit watt thresholds. The lower one asks for 50% throttling and the upper one asks for 90%. Every cycle the block compares the registered power sample against both thresholds. From that comparison it drives two live alarm flags and a throttle-level code.

The block also combines a tolerance flag from each accelerator unit into one summary bit. That bit reads 1 only when every unit can tolerate at least 40 us of memory latency. Two power-limit words arrive from outside the block, each carrying an enable bit. The block holds them for software to read and drives an effective limit for each. The effective limit is forced to zero while the word's enable bit is clear. All state is visible through a 64-bit register window, and each threshold sits in its own byte lane. Software can therefore update one threshold with a single strobed write.

Top module: `pwr_throttle_mon`

## Requirements
- R1: After reset, the throttle code is 0, both alarms are 0, and the threshold word reads back 127 in both threshold fields (value 0x7F7F).
- R2: A read at byte offset 0x08 returns the registered power sample in bits 17:0 and the latency summary in bit 18. All other bits read 0.
- R3: The latency summary is 1 exactly when every bit of the per-unit tolerance input is 1. It follows the input one cycle later.
- R4: A read at byte offset 0x10 returns the low threshold in bits 6:0, the high threshold in bits 14:8, the low alarm in bit 16 and the high alarm in bit 17.
- R5: A write to offset 0x10 with strobe bit 0 set loads the low threshold from write data bits 6:0. Strobe bit 1 loads the high threshold from bits 14:8. A field whose strobe is clear keeps its value.
- R6: The low alarm is 1 when the power sample is greater than or equal to the low threshold, equality included.
- R7: The high alarm is 1 when the power sample is greater than or equal to the high threshold, equality included.
- R8: The throttle code is 2 (90%) whenever the high alarm is set, even if the low alarm is clear. It is 1 (50%) when only the low alarm is set, and 0 (none) otherwise.
- R9: Alarm bits 17:16 and the unused bits 7 and 15 of the threshold word are read-only. Writes to them have no effect, and bits 7 and 15 read 0.
- R10: Reads at offsets 0x18 and 0x20 return the host-side and device-side limit words: limit in bits 14:0 (units of 0.1 W), enable in bit 15. Each effective-limit output carries the limit when its enable bit is 1 and zero otherwise, one cycle after the input.
- R11: A threshold write changes the alarms one cycle after the write edge. A new power input changes the alarms two cycles after it is sampled.
- R12: Reads at any other offset return zero. Read data appears, with its valid strobe, one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_in | input | 18 | Measured power in whole watts |
| unit_tol_in | input | 4 | Per-unit latency tolerance flags |
| host_lim_word | input | 16 | Host-side limit word {enable, limit[14:0]} |
| dev_lim_word | input | 16 | Device-side limit word {enable, limit[14:0]} |
| csr_wr | input | 1 | Register write request |
| csr_rd | input | 1 | Register read request |
| csr_addr | input | 6 | Byte address in the register window |
| csr_wdata | input | 64 | Write data |
| csr_wstrb | input | 8 | Byte-lane write strobes |
| csr_rdata | output | 64 | Read data |
| csr_rvalid | output | 1 | Read data valid |
| throttle_lvl | output | 2 | 0 none, 1 50%, 2 90% |
| alarm_lo | output | 1 | Power at or above the low threshold |
| alarm_hi | output | 1 | Power at or above the high threshold |
| lat_tol | output | 1 | All units tolerate long latency |
| host_lim_eff | output | 15 | Gated host-side limit |
| dev_lim_eff | output | 15 | Gated device-side limit |

## Verification
Power is stepped across each threshold one watt below, exactly at and above it, which separates a greater-or-equal compare from a strict one. The maximum 18-bit sample checks that the wide value is not truncated against the 7-bit thresholds. An inverted setting, with the high threshold below the low one, shows whether the 90% level really takes priority or only appears alongside the 50% alarm. Single-lane strobed writes and writes aimed at the status bits show whether each field is isolated. The limit words are driven with the enable bit both set and clear, and the tolerance vector is driven with all units set and with one unit clear, which tells gating apart from pass-through.

// File: rtl/pwr_thr_pkg.sv
package pwr_thr_pkg;
  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_HALF  = 2'd1,
    LVL_HEAVY = 2'd2
  } thr_lvl_e;

  localparam int OFF_STAT = 'h08;
  localparam int OFF_THR  = 'h10;
  localparam int OFF_HLIM = 'h18;
  localparam int OFF_DLIM = 'h20;

  localparam int THR_LO_POS = 0;
  localparam int THR_HI_POS = 8;
  localparam int ALM_LO_POS = 16;
  localparam int ALM_HI_POS = 17;
endpackage

// File: rtl/pwr_lat_agg.sv
module pwr_lat_agg #(
  parameter int NU = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NU-1:0] tol_in,
  output logic          lat_q
);
  always_ff @(posedge clk) begin
    if (rst) lat_q <= 1'b0;
    else     lat_q <= &tol_in;
  end
endmodule

// File: rtl/pwr_thr_regs.sv
module pwr_thr_regs #(
  parameter int          TW      = 7,
  parameter logic [TW-1:0] THR_RST = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [15:0]   wdata,
  input  logic [1:0]    wstrb,
  output logic [1:0][TW-1:0] thr_q
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        thr_q[g] <= THR_RST;
      else if (wr_en && wstrb[g])
        thr_q[g] <= wdata[g*8 +: TW];
    end
  end
endmodule

// File: rtl/pwr_cmp.sv
module pwr_cmp
  import pwr_thr_pkg::*;
#(
  parameter int PW = 18,
  parameter int TW = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PW-1:0]      pwr_in,
  input  logic [1:0][TW-1:0] thr,
  output logic [PW-1:0]      pwr_q,
  output logic [1:0]         alm_q,
  output thr_lvl_e           lvl_q
);
  logic [1:0] ge;

  always_ff @(posedge clk) begin
    if (rst) pwr_q <= '0;
    else     pwr_q <= pwr_in;
  end

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    assign ge[g] = pwr_q >= PW'(thr[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_q <= '0;
      lvl_q <= LVL_NONE;
    end else begin
      alm_q <= ge;
      if (ge[1])      lvl_q <= LVL_HEAVY;
      else if (ge[0]) lvl_q <= LVL_HALF;
      else            lvl_q <= LVL_NONE;
    end
  end
endmodule

// File: rtl/pwr_lim_regs.sv
module pwr_lim_regs #(
  parameter int LW = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0][LW:0]   word_in,
  output logic [1:0][LW:0]   word_q,
  output logic [1:0][LW-1:0] eff_q
);
  for (genvar g = 0; g < 2; g++) begin : g_lim
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[g] <= '0;
        eff_q[g]  <= '0;
      end else begin
        word_q[g] <= word_in[g];
        eff_q[g]  <= word_in[g][LW] ? word_in[g][LW-1:0] : '0;
      end
    end
  end
endmodule

// File: rtl/pwr_throttle_mon.sv
module pwr_throttle_mon
  import pwr_thr_pkg::*;
#(
  parameter int PW = 18,
  parameter int TW = 7,
  parameter int LW = 15,
  parameter int NU = 4,
  parameter int AW = 6,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pwr_in,
  input  logic [NU-1:0] unit_tol_in,
  input  logic [LW:0]   host_lim_word,
  input  logic [LW:0]   dev_lim_word,
  input  logic          csr_wr,
  input  logic          csr_rd,
  input  logic [AW-1:0] csr_addr,
  input  logic [DW-1:0] csr_wdata,
  input  logic [DW/8-1:0] csr_wstrb,
  output logic [DW-1:0] csr_rdata,
  output logic          csr_rvalid,
  output logic [1:0]    throttle_lvl,
  output logic          alarm_lo,
  output logic          alarm_hi,
  output logic          lat_tol,
  output logic [LW-1:0] host_lim_eff,
  output logic [LW-1:0] dev_lim_eff
);
  localparam int LAT_POS = PW;

  logic [1:0][TW-1:0] thr;
  logic [TW-1:0]      thr_lo, thr_hi;
  logic [PW-1:0]      pwr_q;
  logic [1:0]         alm_q;
  thr_lvl_e           lvl_q;
  logic               lat_q;
  logic [1:0][LW:0]   lim_word_q;
  logic [1:0][LW-1:0] lim_eff_q;
  logic               thr_wr;
  logic [DW-1:0]      rd_mux;
  wire                unused_ok = ^{csr_wdata[DW-1:16], csr_wstrb[DW/8-1:2]};

  assign thr_wr = csr_wr && (csr_addr == AW'(OFF_THR));

  pwr_thr_regs #(.TW(TW)) u_thr (
    .clk(clk), .rst(rst), .wr_en(thr_wr),
    .wdata(csr_wdata[15:0]), .wstrb(csr_wstrb[1:0]), .thr_q(thr)
  );

  assign thr_lo = thr[0];
  assign thr_hi = thr[1];

  pwr_cmp #(.PW(PW), .TW(TW)) u_cmp (
    .clk(clk), .rst(rst), .pwr_in(pwr_in), .thr(thr),
    .pwr_q(pwr_q), .alm_q(alm_q), .lvl_q(lvl_q)
  );

  pwr_lat_agg #(.NU(NU)) u_lat (
    .clk(clk), .rst(rst), .tol_in(unit_tol_in), .lat_q(lat_q)
  );

  pwr_lim_regs #(.LW(LW)) u_lim (
    .clk(clk), .rst(rst), .word_in({dev_lim_word, host_lim_word}),
    .word_q(lim_word_q), .eff_q(lim_eff_q)
  );

  always_comb begin
    rd_mux = '0;
    if (csr_addr == AW'(OFF_STAT)) begin
      rd_mux[PW-1:0]  = pwr_q;
      rd_mux[LAT_POS] = lat_q;
    end else if (csr_addr == AW'(OFF_THR)) begin
      rd_mux[THR_LO_POS +: TW] = thr_lo;
      rd_mux[THR_HI_POS +: TW] = thr_hi;
      rd_mux[ALM_LO_POS]       = alm_q[0];
      rd_mux[ALM_HI_POS]       = alm_q[1];
    end else if (csr_addr == AW'(OFF_HLIM)) begin
      rd_mux[LW:0] = lim_word_q[0];
    end else if (csr_addr == AW'(OFF_DLIM)) begin
      rd_mux[LW:0] = lim_word_q[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata  <= '0;
      csr_rvalid <= 1'b0;
    end else begin
      csr_rvalid <= csr_rd;
      if (csr_rd) csr_rdata <= rd_mux;
    end
  end

  assign throttle_lvl = lvl_q;
  assign alarm_lo     = alm_q[0];
  assign alarm_hi     = alm_q[1];
  assign lat_tol      = lat_q;
  assign host_lim_eff = lim_eff_q[0];
  assign dev_lim_eff  = lim_eff_q[1];
endmodule

// File: rtl/pwr_throttle_mon_chk.sv
module pwr_throttle_mon_chk
  import pwr_thr_pkg::*;
#(
  parameter int PW = 18,
  parameter int TW = 7,
  parameter int LW = 15,
  parameter int NU = 4,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [NU-1:0] unit_tol_in,
  input logic [LW:0]   host_lim_word,
  input logic          csr_wr,
  input logic [AW-1:0] csr_addr,
  input logic [7:0]    csr_wstrb,
  input logic [1:0]    throttle_lvl,
  input logic          alarm_lo,
  input logic          alarm_hi,
  input logic          lat_tol,
  input logic [LW-1:0] host_lim_eff,
  input logic [PW-1:0] pwr_q,
  input logic [TW-1:0] thr_lo,
  input logic [TW-1:0] thr_hi
);
  a_r3_lat_and: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> lat_tol == &$past(unit_tol_in));

  a_r6_lo_cmp: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> alarm_lo == ($past(pwr_q) >= PW'($past(thr_lo))));

  a_r7_hi_cmp: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> alarm_hi == ($past(pwr_q) >= PW'($past(thr_hi))));

  a_r8_heavy: assert property (@(posedge clk) disable iff (rst)
    alarm_hi |-> throttle_lvl == 2'd2);

  a_r8_half: assert property (@(posedge clk) disable iff (rst)
    (alarm_lo && !alarm_hi) |-> throttle_lvl == 2'd1);

  a_r8_none: assert property (@(posedge clk) disable iff (rst)
    (!alarm_lo && !alarm_hi) |-> throttle_lvl == 2'd0);

  a_r5_hi_kept: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(csr_wr && csr_addr == AW'(OFF_THR) && !csr_wstrb[1]))
      |-> $stable(thr_hi));

  a_r5_lo_kept: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(csr_wr && csr_addr == AW'(OFF_THR) && !csr_wstrb[0]))
      |-> $stable(thr_lo));

  a_r10_gate: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(host_lim_word[LW])) |-> host_lim_eff == '0);
endmodule

bind pwr_throttle_mon pwr_throttle_mon_chk #(
  .PW(PW), .TW(TW), .LW(LW), .NU(NU), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .unit_tol_in(unit_tol_in),
  .host_lim_word(host_lim_word), .csr_wr(csr_wr), .csr_addr(csr_addr),
  .csr_wstrb(csr_wstrb), .throttle_lvl(throttle_lvl), .alarm_lo(alarm_lo),
  .alarm_hi(alarm_hi), .lat_tol(lat_tol), .host_lim_eff(host_lim_eff),
  .pwr_q(pwr_q), .thr_lo(thr_lo), .thr_hi(thr_hi)
);

// File: tb/pwr_throttle_mon_bench.sv
module pwr_throttle_mon_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] pwr_in = '0;
  logic [3:0]  unit_tol_in = '0;
  logic [15:0] host_lim_word = '0;
  logic [15:0] dev_lim_word = '0;
  logic        csr_wr = 1'b0;
  logic        csr_rd = 1'b0;
  logic [5:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [7:0]  csr_wstrb = '0;
  logic [63:0] csr_rdata;
  logic        csr_rvalid;
  logic [1:0]  throttle_lvl;
  logic        alarm_lo, alarm_hi, lat_tol;
  logic [14:0] host_lim_eff, dev_lim_eff;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_throttle_mon u_pwr_throttle_mon (
    .clk(clk), .rst(rst), .pwr_in(pwr_in), .unit_tol_in(unit_tol_in),
    .host_lim_word(host_lim_word), .dev_lim_word(dev_lim_word),
    .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_wstrb(csr_wstrb), .csr_rdata(csr_rdata),
    .csr_rvalid(csr_rvalid), .throttle_lvl(throttle_lvl),
    .alarm_lo(alarm_lo), .alarm_hi(alarm_hi), .lat_tol(lat_tol),
    .host_lim_eff(host_lim_eff), .dev_lim_eff(dev_lim_eff)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic csr_write(logic [5:0] a, logic [63:0] d, logic [7:0] s);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d; csr_wstrb = s;
    @(negedge clk);
    csr_wr = 1'b0; csr_wstrb = '0;
  endtask

  task automatic csr_read(logic [5:0] a, output logic [63:0] d);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = a;
    @(negedge clk);
    csr_rd = 1'b0;
    chk("R12", "read valid", 64'(csr_rvalid), 64'd1);
    d = csr_rdata;
  endtask

  task automatic set_pwr(logic [17:0] p);
    @(negedge clk);
    pwr_in = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_out(string req, logic lo, logic hi, logic [1:0] lvl);
    chk(req, "alarm_lo", 64'(alarm_lo), 64'(lo));
    chk(req, "alarm_hi", 64'(alarm_hi), 64'(hi));
    chk(req, "throttle", 64'(throttle_lvl), 64'(lvl));
  endtask

  task automatic t_reset();
    logic [63:0] d;
    expect_out("R1", 1'b0, 1'b0, 2'd0);
    csr_read(6'h10, d);
    chk("R1", "threshold word", d, 64'h7F7F);
  endtask

  task automatic t_status();
    logic [63:0] d;
    unit_tol_in = 4'hF;
    set_pwr(18'h2ABCD);
    chk("R3", "lat all", 64'(lat_tol), 64'd1);
    csr_read(6'h08, d);
    chk("R2", "status word", d, {45'd0, 1'b1, 18'h2ABCD});
    @(negedge clk); unit_tol_in = 4'hB;
    @(negedge clk);
    chk("R3", "lat one clear", 64'(lat_tol), 64'd0);
    csr_read(6'h08, d);
    chk("R2", "status lat clear", d, {46'd0, 18'h2ABCD});
  endtask

  task automatic t_fields();
    logic [63:0] d;
    csr_write(6'h10, 64'hFFFF_FFFF_FFFF_FFA8, 8'h01);
    csr_read(6'h10, d);
    chk("R5", "low only", d[15:0], 16'h7F28);
    chk("R9", "bit7 zero", 64'(d[7]), 64'd0);
    csr_write(6'h10, 64'h0000_0000_0000_D000, 8'h02);
    csr_read(6'h10, d);
    chk("R5", "high only", d[15:0], 16'h5028);
    chk("R9", "bit15 zero", 64'(d[15]), 64'd0);
  endtask

  task automatic t_compare();
    logic [63:0] d;
    set_pwr(18'd39);  expect_out("R6", 1'b0, 1'b0, 2'd0);
    set_pwr(18'd40);  expect_out("R6", 1'b1, 1'b0, 2'd1);
    set_pwr(18'd79);  expect_out("R7", 1'b1, 1'b0, 2'd1);
    set_pwr(18'd80);  expect_out("R7", 1'b1, 1'b1, 2'd2);
    csr_read(6'h10, d);
    chk("R4", "word with both alarms", d, 64'h3_5028);
    set_pwr(18'h3FFFF); expect_out("R8", 1'b1, 1'b1, 2'd2);
    set_pwr(18'd0);     expect_out("R8", 1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_inverted();
    csr_write(6'h10, 64'h1E5A, 8'h03);
    set_pwr(18'd50);
    expect_out("R8", 1'b0, 1'b1, 2'd2);
  endtask

  task automatic t_readonly();
    logic [63:0] d;
    csr_write(6'h10, 64'h2828, 8'h03);
    set_pwr(18'd10);
    csr_write(6'h10, 64'hFFFF_FFFF_FFFF_0000, 8'hFC);
    @(negedge clk);
    expect_out("R9", 1'b0, 1'b0, 2'd0);
    csr_read(6'h10, d);
    chk("R9", "status bits held", d, 64'h2828);
  endtask

  task automatic t_timing();
    csr_write(6'h10, 64'h7F28, 8'h03);
    set_pwr(18'd60);
    chk("R11", "pre write", 64'(alarm_lo), 64'd1);
    csr_write(6'h10, 64'h46, 8'h01);
    chk("R11", "write edge", 64'(alarm_lo), 64'd1);
    @(negedge clk);
    chk("R11", "one after write", 64'(alarm_lo), 64'd0);
    @(negedge clk); pwr_in = 18'd75;
    @(negedge clk);
    chk("R11", "one after sample", 64'(alarm_lo), 64'd0);
    @(negedge clk);
    chk("R11", "two after sample", 64'(alarm_lo), 64'd1);
  endtask

  task automatic t_limits();
    logic [63:0] d;
    @(negedge clk);
    host_lim_word = 16'h8123; dev_lim_word = 16'h0456;
    @(negedge clk);
    chk("R10", "host eff", 64'(host_lim_eff), 64'h0123);
    chk("R10", "dev eff gated", 64'(dev_lim_eff), 64'h0);
    csr_read(6'h18, d); chk("R10", "host word", d, 64'h8123);
    csr_read(6'h20, d); chk("R10", "dev word", d, 64'h0456);
    @(negedge clk);
    host_lim_word = 16'h7FFF; dev_lim_word = 16'hFFFF;
    @(negedge clk);
    chk("R10", "host eff gated", 64'(host_lim_eff), 64'h0);
    chk("R10", "dev eff", 64'(dev_lim_eff), 64'h7FFF);
  endtask

  task automatic t_unmapped();
    logic [63:0] d;
    csr_read(6'h28, d); chk("R12", "offset 0x28", d, 64'h0);
    csr_read(6'h00, d); chk("R12", "offset 0x00", d, 64'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_status();
    t_fields();
    t_compare();
    t_inverted();
    t_readonly();
    t_timing();
    t_limits();
    t_unmapped();
    finish_run();
  end
endmodule